// File: doc/BRIEF.md
# Four-Phase Timed Sequencer

The sequencer cycles forever through four phases, numbered 0 to 3, in ascending order with wrap-around. Each phase lasts a fixed number of enabled clock cycles, taken from a per-phase parameter. One shared down-counter times every phase. When a phase begins, the counter is loaded with that phase's dwell minus one, and it decrements once per enabled cycle. The phase ends in the cycle where the decrement would take the counter below zero. That condition is read from the top bit of the counter's decrement result, which is one bit wider than the largest dwell needs. No zero compare across the full counter width is used.

A host uses the 2-bit phase code to steer other logic. It uses the one-cycle step pulse to start work at each phase boundary. The enable input freezes the sequencer in place without losing the count.

Top module: `phase_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the block goes to phase 0 (`phase_o` = 2'b00) with `step_o` low, and the counter is loaded so that phase 0 then lasts its full dwell.
- R2: Phases advance strictly in the order 00, 01, 10, 11, then back to 00. No code is skipped or repeated out of turn.
- R3: With default parameters, phase 00 lasts 1000 enabled cycles, 01 lasts 555, 10 lasts 666 and 11 lasts 784. Each is measured between consecutive `step_o` pulses, or from reset release to the first pulse.
- R4: `step_o` is high for exactly one cycle: the first cycle in which `phase_o` shows the new phase.
- R5: While `en` is low, `phase_o` holds, `step_o` stays low, and the remaining count is kept. The current phase therefore lasts its dwell plus the number of disabled cycles.
- R6: Asserting `rst` in the middle of a phase abandons that phase. After release, phase 00 runs its full 1000-cycle dwell.
- R7: If `en` drops on what would be the last cycle of a phase, the transition is deferred. It occurs on the first enabled edge after `en` returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low freezes the sequencer |
| phase_o | output | 2 | Current phase code, 00 to 11 |
| step_o | output | 1 | One-cycle pulse in the first cycle of each new phase |

## Verification
The hardest situation to reach is `en` falling exactly on the final cycle of a phase. There, the counter is one decrement away from its sign bit, so a design that latched the end condition early would still advance. The stimulus waits for a step pulse and counts one cycle fewer than the phase's dwell. It then drops `en` for a stretch, checks that nothing moves, and restores `en` to see the transition one edge later. A mid-phase reset and a long disabled stretch in the middle of a phase cover the other ways the shared count can be disturbed.

// File: rtl/phase_sequencer.sv
module phase_sequencer #(
  parameter int unsigned DWELL_P0 = 1000,
  parameter int unsigned DWELL_P1 = 555,
  parameter int unsigned DWELL_P2 = 666,
  parameter int unsigned DWELL_P3 = 784
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [1:0] phase_o,
  output logic       step_o
);

  localparam int unsigned MAX01 = (DWELL_P0 > DWELL_P1) ? DWELL_P0 : DWELL_P1;
  localparam int unsigned MAX23 = (DWELL_P2 > DWELL_P3) ? DWELL_P2 : DWELL_P3;
  localparam int unsigned MAXD  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CW    = $clog2(MAXD + 1) + 1;

  localparam logic [CW-1:0] LOAD0 = CW'(DWELL_P0 - 1);
  localparam logic [CW-1:0] LOAD1 = CW'(DWELL_P1 - 1);
  localparam logic [CW-1:0] LOAD2 = CW'(DWELL_P2 - 1);
  localparam logic [CW-1:0] LOAD3 = CW'(DWELL_P3 - 1);

  logic [3:0]    st;
  logic [3:0]    st_nxt;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_load;
  logic [CW-1:0] cnt_dec;
  logic          done;
  logic          legal;

  assign cnt_dec = cnt - 1'b1;
  assign done    = cnt_dec[CW-1];
  assign legal   = $onehot(st);

  always_comb begin
    case (st)
      4'b0001: begin st_nxt = 4'b0010; cnt_load = LOAD1; end
      4'b0010: begin st_nxt = 4'b0100; cnt_load = LOAD2; end
      4'b0100: begin st_nxt = 4'b1000; cnt_load = LOAD3; end
      default: begin st_nxt = 4'b0001; cnt_load = LOAD0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= 4'b0001;
      cnt    <= LOAD0;
      step_o <= 1'b0;
    end else begin
      step_o <= 1'b0;
      if (!legal) begin
        st  <= 4'b0001;
        cnt <= LOAD0;
      end else if (en) begin
        if (done) begin
          st     <= st_nxt;
          cnt    <= cnt_load;
          step_o <= 1'b1;
        end else begin
          cnt <= cnt_dec;
        end
      end
    end
  end

  assign phase_o = {st[3] | st[2], st[3] | st[1]};

endmodule

module phase_sequencer_chk #(
  parameter int unsigned DWELL_P0 = 1000,
  parameter int unsigned DWELL_P1 = 555,
  parameter int unsigned DWELL_P2 = 666,
  parameter int unsigned DWELL_P3 = 784
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [1:0] phase_o,
  input logic       step_o
);

  logic armed = 1'b0;
  int unsigned ec;
  int unsigned dw;

  always_comb begin
    case (phase_o)
      2'd0:    dw = DWELL_P0;
      2'd1:    dw = DWELL_P1;
      2'd2:    dw = DWELL_P2;
      default: dw = DWELL_P3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
      ec    <= 0;
    end else if (en) begin
      ec <= (ec + 1 == dw) ? 0 : ec + 1;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    armed && $past(rst) && !rst |-> phase_o == 2'd0 && !step_o); // R1

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && phase_o != $past(phase_o) |-> phase_o == $past(phase_o) + 2'd1); // R2

  AST_DWELL_EARLY: assert property (@(posedge clk) disable iff (rst)
    armed && en && (ec + 1 < dw) |=> !step_o && $stable(phase_o)); // R3

  AST_DWELL_END: assert property (@(posedge clk) disable iff (rst)
    armed && en && (ec + 1 == dw) |=> step_o); // R3

  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    armed && step_o |=> !step_o); // R4

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    armed && !en |=> $stable(phase_o) && !step_o); // R5

endmodule

bind phase_sequencer phase_sequencer_chk #(
  .DWELL_P0(DWELL_P0), .DWELL_P1(DWELL_P1),
  .DWELL_P2(DWELL_P2), .DWELL_P3(DWELL_P3)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .phase_o(phase_o), .step_o(step_o)
);

// File: tb/phase_sequencer_tb.sv
`timescale 1ns/1ps
module phase_sequencer_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [1:0] phase_o;
  logic       step_o;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  phase_sequencer u_dut (
    .clk(clk), .rst(rst), .en(en), .phase_o(phase_o), .step_o(step_o)
  );

  function automatic int dwell_of(input int ph);
    case (ph)
      0: return 1000;
      1: return 555;
      2: return 666;
      default: return 784;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_step(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!step_o && n < 5000);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1;
    repeat (3) @(negedge clk);
    chk(phase_o == 2'd0, "R1 phase in reset", phase_o, 0);
    chk(step_o == 1'b0, "R1 step in reset", step_o, 0);
    rst = 1'b0;
  endtask

  task automatic t_first_phase();
    int n;
    wait_step(n);
    chk(n == dwell_of(0), "R1 R3 first dwell", n, dwell_of(0));
    chk(phase_o == 2'd1, "R2 first advance", phase_o, 1);
  endtask

  task automatic t_two_rounds();
    int n;
    int prev;
    for (int i = 0; i < 8; i++) begin
      prev = phase_o;
      wait_step(n);
      chk(n == dwell_of(prev), "R3 dwell", n, dwell_of(prev));
      chk(phase_o == ((prev + 1) % 4), "R2 order", phase_o, (prev + 1) % 4);
      @(negedge clk);
      chk(step_o == 1'b0, "R4 pulse width", step_o, 0);
      chk(phase_o == ((prev + 1) % 4), "R4 phase after pulse", phase_o, (prev + 1) % 4);
      wait_step(n);
      chk(n == dwell_of((prev + 1) % 4) - 1, "R3 dwell tail", n, dwell_of((prev + 1) % 4) - 1);
    end
  endtask

  task automatic t_enable_hold();
    int n;
    int ph;
    bit ok = 1'b1;
    ph = phase_o;
    repeat (100) @(negedge clk);
    en = 1'b0;
    repeat (50) begin
      @(negedge clk);
      if (phase_o != ph[1:0] || step_o) ok = 1'b0;
    end
    chk(ok, "R5 hold while disabled", phase_o, ph);
    en = 1'b1;
    wait_step(n);
    chk(n + 150 == dwell_of(ph) + 50, "R5 stretched dwell", n + 150, dwell_of(ph) + 50);
  endtask

  task automatic t_enable_boundary();
    int ph;
    bit ok = 1'b1;
    ph = phase_o;
    repeat (dwell_of(ph) - 1) @(negedge clk);
    chk(phase_o == ph[1:0] && !step_o, "R7 before last edge", phase_o, ph);
    en = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (phase_o != ph[1:0] || step_o) ok = 1'b0;
    end
    chk(ok, "R7 deferred transition", phase_o, ph);
    en = 1'b1;
    @(negedge clk);
    chk(step_o == 1'b1, "R7 step on resume", step_o, 1);
    chk(phase_o == ((ph + 1) % 4), "R7 phase on resume", phase_o, (ph + 1) % 4);
  endtask

  task automatic t_reset_mid();
    int n;
    repeat (200) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(phase_o == 2'd0 && !step_o, "R6 mid-phase reset", phase_o, 0);
    rst = 1'b0;
    wait_step(n);
    chk(n == dwell_of(0), "R6 full dwell after reset", n, dwell_of(0));
    chk(phase_o == 2'd1, "R6 phase after dwell", phase_o, 1);
  endtask

  initial begin
    t_reset();
    t_first_phase();
    t_two_rounds();
    t_enable_hold();
    t_enable_boundary();
    t_reset_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule